// File: doc/BRIEF.md
# Read-Once Secret Word Store

This block keeps a 256-bit device secret as eight 32-bit words and hands them out through a small request/response read port. A caller presents a word index with a request strobe. On the next clock the block raises a one-cycle ready pulse together with the data. The secret value is fixed when the block is built, through a parameter; nothing at run time can change it.

Two separate gates protect each word. The first is an external privilege enable. While it is low, every read returns zero and uses up nothing. The second is a per-word consumed flag. The first successful read of a word sets its flag, and from then on that word only ever returns zero. Reset is the only thing that clears the flags. Words may be taken in any order, and each flag is independent of the others.

A two-state controller sequences the port:
- `ST_IDLE` waits for a request. On a request it moves to `ST_RESPOND`.
- `ST_RESPOND` drives the ready pulse. It stays in `ST_RESPOND` when a new request arrives in the same cycle, so back-to-back requests work. Otherwise it returns to `ST_IDLE`.

Top module: `secret_vault`

## Requirements
- R1: Eight 32-bit words are selected by a 3-bit index. Word i is bits [32i+31:32i] of the `SECRET` parameter, so index 0 is the least-significant word.
- R2: Every cycle with `req_valid` high produces `rsp_ready` high in exactly the following cycle, and only then. Requests in consecutive cycles each get their own pulse.
- R3: A read (`req_write`=0) of an unconsumed word with `unlock` high returns that word's value on `rsp_data` with the ready pulse, and marks the word consumed.
- R4: A read of a consumed word returns zero, and the word stays consumed until reset.
- R5: Consumed flags are independent, so words can be read successfully in any order.
- R6: A read while `unlock` is low returns zero and does not consume the word. A later read with `unlock` high still returns the value.
- R7: A write request (`req_write`=1) returns zero with its ready pulse and changes neither the secret nor any consumed flag.
- R8: Reset (`rst_n` low, asynchronous) clears all consumed flags and holds `rsp_ready` low and `rsp_data` zero. After reset every word can be read once more.
- R9: `rsp_data` is zero in every cycle in which `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlock | input | 1 | Privilege enable; reads succeed only while high |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 marks the request as a write (ignored) |
| req_index | input | 3 | Word index |
| rsp_ready | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Response word, zero unless a read was granted |

## Verification
The bench builds the block with the default eight 32-bit words and overrides `SECRET` with a pattern in which all words are distinct and non-zero. With that pattern, a wrong-word selection, a swapped word order or a wrongly suppressed reply each produces a value different from the expected one. The bench runs its reads in a scrambled index order with back-to-back requests, so the per-word flags and the self-looping `ST_RESPOND` transition are both exercised. A mid-run reset then makes the whole store readable again.

// File: rtl/vault_pkg.sv
package vault_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RESPOND = 1'b1
    } vault_state_e;
endpackage

// File: rtl/vault_word_bank.sv
module vault_word_bank #(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned WORD_W    = 32,
    parameter logic [NUM_WORDS*WORD_W-1:0] SECRET = '0,
    localparam int unsigned IDX_W = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              take_i,
    output logic [WORD_W-1:0] word_o,
    output logic              used_o
);
    logic [WORD_W-1:0]    words [NUM_WORDS];
    logic [NUM_WORDS-1:0] used_q;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        assign words[g] = SECRET[g*WORD_W +: WORD_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                used_q[g] <= 1'b0;
            else if (take_i && (sel_idx == IDX_W'(g)))
                used_q[g] <= 1'b1;
        end

        // once taken, a word stays taken until reset
        assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            used_q[g] |=> used_q[g]);
    end

    assign word_o = words[sel_idx];
    assign used_o = used_q[sel_idx];

    // flags move only on a granted read (R6, R7)
    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(used_q));
endmodule

// File: rtl/vault_access_fsm.sv
module vault_access_fsm
    import vault_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [WORD_W-1:0] load_data_i,
    output logic              rsp_ready_o,
    output logic [WORD_W-1:0] rsp_data_o
);
    vault_state_e      state_q, state_d;
    logic [WORD_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_i) state_d = ST_RESPOND;
            ST_RESPOND: state_d = req_i ? ST_RESPOND : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= req_i ? load_data_i : '0;
        end
    end

    always_comb begin
        rsp_ready_o = (state_q == ST_RESPOND);
        rsp_data_o  = rsp_ready_o ? data_q : '0;
    end

    assert_ready_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_ready_o);
    assert_no_spurious_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !rsp_ready_o);
endmodule

// File: rtl/secret_vault.sv
module secret_vault #(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned WORD_W    = 32,
    parameter logic [NUM_WORDS*WORD_W-1:0] SECRET = {NUM_WORDS{32'h5A5A_C3C3}}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         unlock,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [$clog2(NUM_WORDS)-1:0] req_index,
    output logic                         rsp_ready,
    output logic [WORD_W-1:0]            rsp_data
);
    localparam int unsigned IDX_W = $clog2(NUM_WORDS);

    logic              grant;
    logic              sel_used;
    logic [WORD_W-1:0] sel_word;
    logic [WORD_W-1:0] load_word;

    assign grant     = req_valid && !req_write && unlock && !sel_used;
    assign load_word = grant ? sel_word : '0;

    vault_word_bank #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .SECRET    (SECRET)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_idx (req_index[IDX_W-1:0]),
        .take_i  (grant),
        .word_o  (sel_word),
        .used_o  (sel_used)
    );

    vault_access_fsm #(
        .WORD_W (WORD_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_valid),
        .load_data_i (load_word),
        .rsp_ready_o (rsp_ready),
        .rsp_data_o  (rsp_data)
    );

    assert_locked_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !unlock) |=> (rsp_data == '0));
    assert_consumed_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel_used) |=> (rsp_data == '0));
    assert_write_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_data == '0));
    assert_idle_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |-> (rsp_data == '0));
endmodule

// File: tb/secret_vault_tb_top.sv
module secret_vault_tb_top;
    localparam logic [255:0] TB_SECRET = {
        32'h7E11_9A04, 32'h61C3_0B58, 32'h5D2A_E7F6, 32'h4B90_1C3D,
        32'h3A77_D012, 32'h29E4_5FA8, 32'h1836_C4B9, 32'h0F5B_2E71};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unlock = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_index = '0;
    logic        rsp_ready;
    logic [31:0] rsp_data;

    int tests = 0;
    int fails = 0;
    bit used [8];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    secret_vault #(.SECRET(TB_SECRET)) dut_i (
        .clk(clk), .rst_n(rst_n), .unlock(unlock), .req_valid(req_valid),
        .req_write(req_write), .req_index(req_index),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data));

    function automatic logic [31:0] word_of(int i);
        return TB_SECRET[i*32 +: 32];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: drives one request at a negedge and pushes the expected reply
    task automatic issue(bit wr, int idx, bit en, string tag);
        logic [31:0] e;
        req_valid = 1'b1; req_write = wr; req_index = 3'(idx); unlock = en;
        e = '0;
        if (!wr && en && !used[idx]) begin
            e = word_of(idx);
            used[idx] = 1'b1;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_valid = 1'b0; req_write = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares every cycle just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                string t;
                logic [31:0] e;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                check({t, " ready"}, 32'(rsp_ready), 32'd1);
                check({t, " data"}, rsp_data, e);
            end else begin
                check("R2 no ready without request", 32'(rsp_ready), 32'd0);
                check("R9 idle data zero", rsp_data, 32'd0);
            end
        end
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R8 ready low in reset", 32'(rsp_ready), 32'd0);
        check("R8 data zero in reset", rsp_data, 32'd0);
        rst_n = 1'b1;
        idle(2);
        issue(0, 2, 0, "R6 locked read zero");
        issue(0, 2, 1, "R6 later unlocked read gives value");
        issue(1, 5, 1, "R7 write reply zero");
        issue(0, 5, 1, "R7 word intact after write");
        for (int k = 0; k < 8; k++) begin
            int order [8] = '{3, 0, 7, 5, 1, 6, 2, 4};
            issue(0, order[k], 1, (order[k] == 2 || order[k] == 5) ?
                  "R4 consumed word reads zero" : "R1 R3 R5 scrambled-order read");
        end
        idle(1);
        issue(0, 3, 1, "R4 reread still zero");
        issue(1, 0, 0, "R7 locked write zero");
        idle(3);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) used[i] = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        issue(0, 7, 0, "R6 locked after reset");
        for (int i = 0; i < 8; i++) issue(0, i, 1, "R8 readable again after reset");
        issue(0, 0, 1, "R4 consumed after second pass");
        idle(3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule